// File: doc/BRIEF.md
# Four-Bit Pseudo-Random Pattern Generator

This block is a four-bit linear feedback shift register that produces a fixed pseudo-random sequence of patterns. The state is written A3 A2 A1 A0 from MSB to LSB. On every clock edge where shifting is enabled, the contents move one place toward A0. A new bit formed as A1 XOR A0 enters at A3. With these taps the register steps through all fifteen nonzero values in a fixed order and then repeats.

The surrounding logic can start the sequence from any point by loading a seed. A seed of all zeros would freeze the register, so it is replaced by 0001. The block gives out the full four-bit pattern in parallel. It also gives a serial bit, which is A0 of the present state, that is, the bit that the next shift moves out.

Top module: `lfsr4_gen`

## Requirements
- R1: While `rst_n` is low the state is 1101, and it remains 1101 at the first edge after release when neither load nor shift is requested.
- R2: On an edge with `load_i` high, the state becomes `seed_i` (when nonzero), whatever the value of `shift_en_i`.
- R3: On an edge with `load_i` high and `seed_i` equal to 0000, the state becomes 0001.
- R4: On an edge with `load_i` low and `shift_en_i` high, the new state is {A1^A0, A3, A2, A1} of the old state.
- R5: On an edge with both `load_i` and `shift_en_i` low, the state keeps its value.
- R6: `ser_o` equals bit A0 (bit 0) of `state_o` at all times, so it shows the bit that the next shift moves out.
- R7: Starting at 1101 and shifting on every edge, the states are 1101, 1110, 1111, 0111, 0011, 0001, 1000, 0100, 0010, 1001, 1100, 0110, 1011, 0101, 1010, and the fifteenth shift returns the state to 1101.
- R8: The state is never 0000 while out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes happen on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset to 1101 |
| load_i | input | 1 | Synchronous seed load; takes priority over shifting |
| seed_i | input | 4 | Seed value; 0000 is replaced by 0001 |
| shift_en_i | input | 1 | Shift enable |
| state_o | output | 4 | Current state, bit 3 = A3 down to bit 0 = A0 |
| ser_o | output | 1 | Serial output, equal to A0 |

## Verification
A load, a shift or a hold shows on `state_o` one rising edge after the inputs are applied, because only one register sits between the inputs and the output. `ser_o` follows the state with no added delay. The bench sets its inputs on the falling edge. It compares `state_o` and `ser_o` with its own model on the next falling edge, which falls half a period after the one rising edge that can change them. It samples before it drives the next inputs, so each check sees the result of exactly one edge.

// File: rtl/lfsr4_pkg.sv
package lfsr4_pkg;
    localparam int LFSR_W = 4;

    typedef struct packed {
        logic [LFSR_W-1:0] bits;
    } lfsr_state_t;
endpackage

// File: rtl/lfsr4_seed_guard.sv
module lfsr4_seed_guard #(
    parameter int W = 4
) (
    input  logic [W-1:0] seed_i,
    output logic [W-1:0] safe_o
);
    localparam logic [W-1:0] ESCAPE = {{(W-1){1'b0}}, 1'b1};

    always_comb begin
        safe_o = (seed_i == '0) ? ESCAPE : seed_i;
    end
endmodule

// File: rtl/lfsr4_step.sv
module lfsr4_step #(
    parameter int W      = 4,
    parameter int TAP_HI = 1,
    parameter int TAP_LO = 0
) (
    input  logic [W-1:0] cur_i,
    output logic [W-1:0] nxt_o
);
    logic fb;

    always_comb begin
        fb    = cur_i[TAP_HI] ^ cur_i[TAP_LO];
        nxt_o = {fb, cur_i[W-1:1]};
    end
endmodule

// File: rtl/lfsr4_gen.sv
module lfsr4_gen
    import lfsr4_pkg::*;
#(
    parameter logic [LFSR_W-1:0] RESET_STATE = 4'b1101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [LFSR_W-1:0] seed_i,
    input  logic              shift_en_i,
    output logic [LFSR_W-1:0] state_o,
    output logic              ser_o
);
    localparam int W = LFSR_W;

    lfsr_state_t       st_d, st_q;
    logic [W-1:0]      seed_safe;
    logic [W-1:0]      stepped;

    lfsr4_seed_guard #(.W(W)) u_guard (
        .seed_i (seed_i),
        .safe_o (seed_safe)
    );

    lfsr4_step #(.W(W), .TAP_HI(1), .TAP_LO(0)) u_step (
        .cur_i (st_q.bits),
        .nxt_o (stepped)
    );

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.bits = seed_safe;
        end else if (shift_en_i) begin
            st_d.bits = stepped;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.bits <= RESET_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    assign state_o = st_q.bits;
    assign ser_o   = st_q.bits[0];

    // R2
    load_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && seed_i != '0) |=> (state_o == $past(seed_i)));

    // R3
    zero_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && seed_i == '0) |=> (state_o == 4'b0001));

    // R4
    shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && shift_en_i) |=>
        (state_o == {$past(state_o[1]) ^ $past(state_o[0]), $past(state_o[3:1])}));

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !shift_en_i) |=> $stable(state_o));

    // R8
    never_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_o != '0);
endmodule

// File: tb/sim_lfsr4_gen.sv
module sim_lfsr4_gen;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_i = 1'b0;
    logic [3:0] seed_i = 4'b0000;
    logic       shift_en_i = 1'b0;
    logic [3:0] state_o;
    logic       ser_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic [3:0] model;
    logic       done = 1'b0;

    lfsr4_gen u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_i),
        .seed_i     (seed_i),
        .shift_en_i (shift_en_i),
        .state_o    (state_o),
        .ser_o      (ser_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [3:0] next_of(logic [3:0] s, logic ld, logic [3:0] sd, logic en);
        if (ld) return (sd == 4'b0000) ? 4'b0001 : sd;
        if (en) return {s[1] ^ s[0], s[3:1]};
        return s;
    endfunction

    function automatic logic [3:0] seq_at(int i);
        logic [3:0] s = 4'b1101;
        for (int k = 0; k < i; k++) s = {s[1] ^ s[0], s[3:1]};
        return s;
    endfunction

    task automatic check(string req, logic [3:0] exp);
        n_cmp++;
        if (state_o !== exp) begin
            n_bad++;
            $display("FAIL %s state actual=%b expected=%b", req, state_o, exp);
        end
        n_cmp++;
        if (ser_o !== exp[0]) begin
            n_bad++;
            $display("FAIL R6 %s ser actual=%b expected=%b", req, ser_o, exp[0]);
        end
        n_cmp++;
        if (state_o === 4'b0000) begin
            n_bad++;
            $display("FAIL R8 state actual=%b expected=nonzero", state_o);
        end
    endtask

    task automatic cyc(logic ld, logic [3:0] sd, logic en, string req);
        load_i = ld; seed_i = sd; shift_en_i = en;
        model = next_of(model, ld, sd, en);
        @(negedge clk);
        check(req, model);
    endtask

    initial begin
        logic [3:0] listed [15] = '{4'b1101, 4'b1110, 4'b1111, 4'b0111, 4'b0011,
                                    4'b0001, 4'b1000, 4'b0100, 4'b0010, 4'b1001,
                                    4'b1100, 4'b0110, 4'b1011, 4'b0101, 4'b1010};
        void'($urandom(32'd4242));
        model = 4'b1101;
        @(negedge clk);
        check("R1", 4'b1101);
        @(negedge clk);
        rst_n = 1'b1;
        cyc(1'b0, 4'b0000, 1'b0, "R1");
        // R7: walk the whole cycle against the listed order
        for (int i = 1; i <= 15; i++) begin
            cyc(1'b0, 4'b0000, 1'b1, "R7");
            n_cmp++;
            if (state_o !== listed[i % 15] || seq_at(i) !== listed[i % 15]) begin
                n_bad++;
                $display("FAIL R7 step %0d actual=%b expected=%b", i, state_o, listed[i % 15]);
            end
        end
        // R5 hold
        cyc(1'b0, 4'b1010, 1'b0, "R5");
        cyc(1'b0, 4'b0110, 1'b0, "R5");
        // R2 load with and without shift
        cyc(1'b1, 4'b0110, 1'b1, "R2");
        cyc(1'b1, 4'b1000, 1'b0, "R2");
        cyc(1'b1, 4'b1111, 1'b1, "R2");
        // R3 zero seed
        cyc(1'b1, 4'b0000, 1'b1, "R3");
        cyc(1'b1, 4'b0000, 1'b0, "R3");
        // R4 single steps after load
        cyc(1'b0, 4'b0000, 1'b1, "R4");
        cyc(1'b0, 4'b1111, 1'b1, "R4");
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic       ld = (($urandom % 8) == 0);
            logic [3:0] sd = 4'($urandom);
            logic       en = (($urandom % 4) != 0);
            cyc(ld, sd, en, ld ? "R2" : (en ? "R4" : "R5"));
        end
        // async reset mid-run returns to 1101
        rst_n = 1'b0;
        model = 4'b1101;
        @(negedge clk);
        check("R1", 4'b1101);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule